// File: doc/BRIEF.md
# Main Clock Loss Monitor

This block watches a main clock from a separate, always-running sampling clock. The main clock is passed through a synchronizer into the sampling domain, and its edges are detected there. A counter measures how long the main clock has gone without toggling. If that gap reaches a programmable number of sampling cycles, the block issues a one-cycle reset request to the system reset controller.

Software arms the monitor through a write-once enable. Once the enable is set, only a reset can clear it. A reset-source flag records that the monitor caused a reset. The flag survives the system reset that follows, so software can read the cause afterwards. Four status inputs pause monitoring:
- the stabilization wait after leaving stop mode,
- a deliberate main-clock shutdown,
- a stalled sampling clock,
- the CPU running from the internal oscillator.

A controlling state machine has four states:
- `ST_OFF`: monitor not armed.
- `ST_WATCH`: counting sampling cycles between main-clock edges.
- `ST_PAUSE`: a suspension input is active.
- `ST_TRIP`: the single cycle in which the request is driven.

Its transitions are:
- OFF→WATCH: armed, no suspension.
- OFF→PAUSE: armed while suspended.
- WATCH→PAUSE: suspension begins.
- WATCH→TRIP: timeout reached.
- PAUSE→WATCH: suspension ends.
- TRIP→WATCH: no suspension.
- TRIP→PAUSE: suspended.

Top module: `mclk_loss_mon`

## Requirements
- R1: A main clock whose half-period is shorter than `timeout_cyc` sampling cycles never produces a reset request.
- R2: With the monitor armed, no suspension active and the main clock stopped, `rst_req` first rises between `timeout_cyc` and `timeout_cyc`+4 sampling cycles after the enabling write.
- R3: `rst_req` is high for exactly one sampling cycle per trip.
- R4: A write of 0 to the enable (`en_we` with `en_wdata`=0) has no effect once `mon_en` is 1.
- R5: `mon_en` is 0 after `por_n` or `sys_rst_n` is asserted (both active low).
- R6: Each trip sets `rst_src_flag` in the cycle after `rst_req`. Asserting `sys_rst_n` does not clear the flag.
- R7: `rst_src_flag` is cleared by `flag_we` with `flag_wdata`=1, or by `por_n`. A flag write with data 0 leaves it unchanged.
- R8: No reset request is issued while any of `sus_stab`, `sus_main_off`, `sus_samp_dead` or `sus_cpu_int` is 1. Each is an active-high suspension input.
- R9: The timeout count restarts from zero when monitoring resumes after a suspension. Time spent before the pause does not count towards a trip.
- R10: While `mon_en` is 0, `rst_req` stays 0 whatever the main clock does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| samp_clk | input | 1 | Sampling (internal oscillator) clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, clears enable and state but not the flag |
| main_clk | input | 1 | Monitored main clock, asynchronous to `samp_clk` |
| timeout_cyc | input | TW | Trip threshold in sampling cycles without a main-clock edge |
| en_we | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable write data |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data, 1 clears |
| sus_stab | input | 1 | Oscillator stabilization after stop-mode release |
| sus_main_off | input | 1 | Main clock deliberately stopped |
| sus_samp_dead | input | 1 | Sampling clock reported stopped |
| sus_cpu_int | input | 1 | CPU running from internal oscillator |
| mon_en | output | 1 | Monitor armed |
| rst_src_flag | output | 1 | Monitor-caused reset recorded |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume several things about the inputs:
- The suspension inputs are synchronous to `samp_clk` and steady between edges.
- `timeout_cyc` stays constant while the monitor is in `ST_WATCH`.
- `main_clk` may change at any time; it is used only through the synchronizer.

The stimulus respects these assumptions:
- Every input, including `main_clk`, is changed only on the falling edge of the sampling clock.
- The threshold is changed only right after a power-on reset, before arming.
- Suspension inputs are held for whole cycles.

// File: rtl/mclk_mon_pkg.sv
package mclk_mon_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_PAUSE = 2'd2,
        ST_TRIP  = 2'd3
    } mon_state_t;

    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/mclk_edge_sync.sv
module mclk_edge_sync #(
    parameter int STAGES = mclk_mon_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_seen
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN-2:0], async_in};
    end

    // either transition of the synchronized level counts as activity
    assign edge_seen = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];
endmodule

// File: rtl/mclk_gap_counter.sv
module mclk_gap_counter #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          edge_seen,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap_q <= '0;
        else if (!run || edge_seen) gap_q <= '0;
        else if (gap_q != CNT_MAX) gap_q <= gap_q + 1'b1;
    end

    assign expired = run && !edge_seen && (gap_q >= limit);

    // R9
    gap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (gap_q == '0));

    // R1
    edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && edge_seen) |=> (gap_q == '0));
endmodule

// File: rtl/mclk_mon_regs.sv
module mclk_mon_regs (
    input  logic clk,
    input  logic por_n,
    input  logic any_rst_n,
    input  logic en_we,
    input  logic en_wdata,
    input  logic flag_we,
    input  logic flag_wdata,
    input  logic trip,
    output logic mon_en,
    output logic rst_src_flag
);
    logic en_q;
    logic flag_q;

    always_ff @(posedge clk or negedge any_rst_n) begin
        if (!any_rst_n)            en_q <= 1'b0;
        else if (en_we && en_wdata) en_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                      flag_q <= 1'b0;
        else if (trip)                   flag_q <= 1'b1;
        else if (flag_we && flag_wdata)  flag_q <= 1'b0;
    end

    assign mon_en       = en_q;
    assign rst_src_flag = flag_q;

    // R4
    en_sticky_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
        mon_en |=> mon_en);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        trip |=> rst_src_flag);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_src_flag && !(flag_we && flag_wdata)) |=> rst_src_flag);
endmodule

// File: rtl/mclk_loss_mon.sv
module mclk_loss_mon
    import mclk_mon_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          samp_clk,
    input  logic          por_n,
    input  logic          sys_rst_n,
    input  logic          main_clk,
    input  logic [TW-1:0] timeout_cyc,
    input  logic          en_we,
    input  logic          en_wdata,
    input  logic          flag_we,
    input  logic          flag_wdata,
    input  logic          sus_stab,
    input  logic          sus_main_off,
    input  logic          sus_samp_dead,
    input  logic          sus_cpu_int,
    output logic          mon_en,
    output logic          rst_src_flag,
    output logic          rst_req
);
    localparam int NSUS = 4;

    logic            any_rst_n;
    logic [NSUS-1:0] sus_vec;
    logic            suspend;
    logic            edge_seen;
    logic            expired;
    logic            cnt_run;
    mon_state_t      state_q;
    mon_state_t      state_d;

    assign any_rst_n = por_n & sys_rst_n;
    assign sus_vec   = {sus_cpu_int, sus_samp_dead, sus_main_off, sus_stab};
    assign suspend   = |sus_vec;

    mclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (samp_clk),
        .rst_n     (any_rst_n),
        .async_in  (main_clk),
        .edge_seen (edge_seen)
    );

    mclk_gap_counter #(.TW(TW)) u_gap (
        .clk       (samp_clk),
        .rst_n     (any_rst_n),
        .run       (cnt_run),
        .edge_seen (edge_seen),
        .limit     (timeout_cyc),
        .expired   (expired)
    );

    mclk_mon_regs u_regs (
        .clk          (samp_clk),
        .por_n        (por_n),
        .any_rst_n    (any_rst_n),
        .en_we        (en_we),
        .en_wdata     (en_wdata),
        .flag_we      (flag_we),
        .flag_wdata   (flag_wdata),
        .trip         (rst_req),
        .mon_en       (mon_en),
        .rst_src_flag (rst_src_flag)
    );

    always_ff @(posedge samp_clk or negedge any_rst_n) begin
        if (!any_rst_n) state_q <= ST_OFF;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (mon_en) state_d = suspend ? ST_PAUSE : ST_WATCH;
            ST_WATCH: begin
                if (suspend)      state_d = ST_PAUSE;
                else if (expired) state_d = ST_TRIP;
            end
            ST_PAUSE: if (!suspend) state_d = ST_WATCH;
            ST_TRIP:  state_d = suspend ? ST_PAUSE : ST_WATCH;
            default:  state_d = ST_OFF;
        endcase
    end

    always_comb begin
        rst_req = (state_q == ST_TRIP);
        cnt_run = (state_q == ST_WATCH);
    end

    // R3
    req_pulse_chk: assert property (@(posedge samp_clk) disable iff (!any_rst_n)
        rst_req |=> !rst_req);

    // R8
    req_suspend_chk: assert property (@(posedge samp_clk) disable iff (!any_rst_n)
        suspend |=> !rst_req);

    // R10
    req_disarmed_chk: assert property (@(posedge samp_clk) disable iff (!any_rst_n)
        !mon_en |-> !rst_req);

    // R2
    req_watch_chk: assert property (@(posedge samp_clk) disable iff (!any_rst_n)
        $rose(rst_req) |-> $past(cnt_run));
endmodule

// File: tb/test_mclk_loss_mon.sv
`timescale 1ns/1ps
module test_mclk_loss_mon;
    localparam int TW = 16;
    localparam int NV = 8;
    // stimulus vectors: threshold, main half-period (0 = stopped),
    // suspension mask {cpu_int, samp_dead, main_off, stab}, trip expected
    localparam int          V_TO  [NV] = '{16, 16, 16, 16, 16, 16, 8, 4};
    localparam int          V_HP  [NV] = '{3,  0,  0,  0,  0,  0,  6, 8};
    localparam logic [3:0]  V_SUS [NV] = '{4'h0, 4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'h0, 4'h0};
    localparam logic        V_EXP [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam string       V_REQ [NV] = '{"R1", "R2", "R8", "R8", "R8", "R8", "R1", "R2"};

    logic          samp_clk = 1'b0;
    logic          por_n = 1'b0, sys_rst_n = 1'b0, main_clk = 1'b0;
    logic [TW-1:0] timeout_cyc = 16'd16;
    logic          en_we = 1'b0, en_wdata = 1'b0, flag_we = 1'b0, flag_wdata = 1'b0;
    logic          sus_stab = 1'b0, sus_main_off = 1'b0, sus_samp_dead = 1'b0, sus_cpu_int = 1'b0;
    logic          mon_en, rst_src_flag, rst_req;

    int n_checks = 0, n_errors = 0;
    int half_per = 0, mcnt = 0, pulses = 0, doubles = 0;
    logic prev_req = 1'b0;

    always #2 samp_clk = ~samp_clk;

    mclk_loss_mon #(.TW(TW)) i_mclk_loss_mon (.*);

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge samp_clk);
            if (half_per != 0) begin
                mcnt++;
                if (mcnt >= half_per) begin main_clk = ~main_clk; mcnt = 0; end
            end
            if (rst_req) pulses++;
            if (rst_req && prev_req) doubles++;
            prev_req = rst_req;
        end
    endtask

    task automatic do_por();
        @(negedge samp_clk);
        por_n = 1'b0; sys_rst_n = 1'b0;
        tick(2);
        por_n = 1'b1; sys_rst_n = 1'b1;
        tick(1);
        pulses = 0; doubles = 0; prev_req = 1'b0;
    endtask

    task automatic wr_en(input logic v);
        @(negedge samp_clk); en_we = 1'b1; en_wdata = v;
        @(negedge samp_clk); en_we = 1'b0; en_wdata = 1'b0;
    endtask

    task automatic wr_flag(input logic v);
        @(negedge samp_clk); flag_we = 1'b1; flag_wdata = v;
        @(negedge samp_clk); flag_we = 1'b0; flag_wdata = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge samp_clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int t;
        // reset state: R5, R7, R10
        do_por();
        check(mon_en == 1'b0, "R5", mon_en, 0);
        check(rst_src_flag == 1'b0, "R7", rst_src_flag, 0);
        check(rst_req == 1'b0, "R10", rst_req, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            half_per = 0; main_clk = 1'b0; mcnt = 0;
            {sus_cpu_int, sus_samp_dead, sus_main_off, sus_stab} = 4'h0;
            do_por();
            timeout_cyc = TW'(V_TO[i]);
            half_per = V_HP[i];
            {sus_cpu_int, sus_samp_dead, sus_main_off, sus_stab} = V_SUS[i];
            wr_en(1'b1);
            pulses = 0;
            tick(100);
            check((pulses > 0) == V_EXP[i], V_REQ[i], pulses, int'(V_EXP[i]));
            check(rst_src_flag == V_EXP[i], "R6", rst_src_flag, int'(V_EXP[i]));
            check(doubles == 0, "R3", doubles, 0);
        end
        {sus_cpu_int, sus_samp_dead, sus_main_off, sus_stab} = 4'h0;

        // R2: trip timing with stopped main clock, threshold 10
        half_per = 0;
        do_por();
        timeout_cyc = 16'd10;
        wr_en(1'b1);
        t = 0;
        while (!rst_req && t < 40) begin tick(1); t++; end
        check(t >= 10 && t <= 14, "R2", t, 12);
        tick(1);
        check(rst_req == 1'b0, "R3", rst_req, 0);
        check(rst_src_flag == 1'b1, "R6", rst_src_flag, 1);

        // R4: writing 0 to the enable is ignored
        wr_en(1'b0);
        tick(2);
        check(mon_en == 1'b1, "R4", mon_en, 1);

        // R5 / R6: system reset clears enable, keeps flag
        @(negedge samp_clk); sys_rst_n = 1'b0;
        tick(2);
        sys_rst_n = 1'b1;
        tick(1);
        check(mon_en == 1'b0, "R5", mon_en, 0);
        check(rst_src_flag == 1'b1, "R6", rst_src_flag, 1);

        // R10: disarmed, stopped clock, no request
        pulses = 0;
        tick(60);
        check(pulses == 0, "R10", pulses, 0);

        // R7: flag write 0 ignored, write 1 clears
        wr_flag(1'b0);
        tick(1);
        check(rst_src_flag == 1'b1, "R7", rst_src_flag, 1);
        wr_flag(1'b1);
        tick(1);
        check(rst_src_flag == 1'b0, "R7", rst_src_flag, 0);

        // R7: power-on reset clears the flag after a trip
        wr_en(1'b1);
        tick(30);
        check(rst_src_flag == 1'b1, "R6", rst_src_flag, 1);
        do_por();
        check(rst_src_flag == 1'b0, "R7", rst_src_flag, 0);

        // R9: suspension restarts the count
        timeout_cyc = 16'd16;
        wr_en(1'b1);
        pulses = 0;
        tick(10);
        sus_stab = 1'b1;
        tick(3);
        sus_stab = 1'b0;
        tick(12);
        check(pulses == 0, "R9", pulses, 0);
        tick(12);
        check(pulses >= 1, "R9", pulses, 1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule